// File: doc/BRIEF.md
# Sequential Integer Divider with Overflow Detection

This block divides 64-bit integers one quotient bit per clock cycle for the execute stage of a 64-bit processor. One start pulse captures the dividend, the divisor and the mode flags. The mode flags select signed or unsigned operation, 32-bit or 64-bit operands, quotient or remainder, and an extended form in which the dividend is shifted up by the operand width. After a fixed number of cycles the block raises a one-cycle done pulse. In the same cycle it presents a 64-bit result and a 32-bit condition word whose top nibble is condition field 0.

The iteration runs one step longer than the operand width. The extra leading quotient bit has weight 2^64 and flags every division whose quotient cannot exist in 64 bits, including a zero divisor. A range check after the last step also catches quotients that are too large for the selected signedness and size. In every such case the block returns zero and a condition word with only the equal bit set. The block is reset from the core reset (active low), not from the global system reset.

Top module: `seqDivider`

## Requirements
- R1: While and after reset (rstN low), doneOut, resultOut and condOut are all zero.
- R2: doneOut is high for exactly one cycle, on the 66th rising clock edge after the edge that samples startIn high.
- R3: A startIn pulse that arrives while an operation is in progress is ignored, and the result is the result of the operation already running.
- R4: Unsigned quotient and remainder are exact. In 32-bit mode only the low 32 bits of each operand are used and the upper 32 result bits are zero.
- R5: Signed quotient truncates toward zero. In 32-bit mode the upper 32 result bits are zero, even for a negative quotient.
- R6: A signed remainder takes the sign of the dividend. In 32-bit mode its low 32 bits are sign-extended to 64 bits, so a negative remainder has all ones in the upper half.
- R7: A divisor of zero (of the selected width) gives resultOut = 0 and condOut = 0x20000000.
- R8: In extended mode (isExtended high, quotient selected), the dividend is opA·2^64 in 64-bit mode and opA[31:0]·2^32 in 32-bit mode. In 64-bit mode, |opA| >= |opB| gives the zero result and condOut = 0x20000000.
- R9: A quotient outside the representable range gives resultOut = 0 and condOut = 0x20000000. The ranges are [0, 2^64) and [0, 2^32) for unsigned, and [-2^63, 2^63) and [-2^31, 2^31) for signed.
- R10: For a successful operation with recordIn high, condOut bit 31 = result negative (bit 63), bit 30 = result positive, bit 29 = result zero, and bit 28 = sumOvIn. All other bits are zero. With recordIn low, condOut is zero.
- R11: In remainder mode the extended flag has no effect, and the only failure is a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Core reset, active low |
| startIn | input | 1 | Start pulse; captures operands and flags when idle |
| opA | input | 64 | Dividend |
| opB | input | 64 | Divisor |
| isSigned | input | 1 | Signed operation |
| is32 | input | 1 | 32-bit operand size |
| isModulo | input | 1 | Return the remainder instead of the quotient |
| isExtended | input | 1 | Extended dividend (quotient only) |
| recordIn | input | 1 | Produce the condition word |
| sumOvIn | input | 1 | Summary-overflow bit copied into the condition word |
| doneOut | output | 1 | One-cycle completion pulse |
| resultOut | output | 64 | Quotient or remainder |
| condOut | output | 32 | Condition word, field 0 in bits 31:28 |

## Verification
Random operands mixed over all sixteen mode combinations are compared with a model that uses wide arithmetic. These cases separate the sign handling, the 32-bit truncation and the extension rules from the core iteration. Divisors are often shrunk to small magnitudes, so that extended divisions sometimes fit and sometimes overflow. Directed cases cover the most negative value divided by -1 at both widths, a zero divisor, 32-bit signed quotients and remainders with negative values (upper half zero or all ones), record on and off, and a second start pulse during a run.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divStateT;

  typedef struct packed {
    logic load;
    logic step;
    logic first;
    logic finish;
  } divStrobeT;
endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int W = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  output divStrobeT strobe
);
  localparam int CW = $clog2(W + 1);

  divStateT state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE: strobe.load = startIn;
      ST_RUN: begin
        strobe.step  = 1'b1;
        strobe.first = (stepCnt == '0);
      end
      ST_FIN:  strobe.finish = 1'b1;
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (startIn) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(W)) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !strobe.finish);

  // R3
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> !strobe.load);
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  divStrobeT       strobe,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            isSigned,
  input  logic            is32,
  input  logic            isModulo,
  input  logic            isExtended,
  input  logic            recordIn,
  input  logic            sumOvIn,
  output logic            doneOut,
  output logic [W-1:0]    resultOut,
  output logic [31:0]     condOut
);
  localparam int H = W / 2;
  localparam logic [W:0] LIM_FULL = {{W{1'b0}}, 1'b1} << (W - 1);
  localparam logic [W:0] LIM_HALF = {{W{1'b0}}, 1'b1} << (H - 1);
  localparam logic [31:0] FAIL_COND = 32'h2000_0000;

  logic [W-1:0] remReg, divReg, lowReg;
  logic [W:0]   qReg;
  logic sgnR, w32R, modR, recR, soR, negQ, negR;

  // operand preparation
  logic sa, sb, extEff;
  logic [W-1:0] magA, magB, hiInit, loInit;
  always_comb begin
    extEff = isExtended & ~isModulo;
    if (is32) begin
      sa   = isSigned & opA[H-1];
      sb   = isSigned & opB[H-1];
      magA = {{H{1'b0}}, (sa ? -opA[H-1:0] : opA[H-1:0])};
      magB = {{H{1'b0}}, (sb ? -opB[H-1:0] : opB[H-1:0])};
      hiInit = '0;
      loInit = extEff ? (magA << H) : magA;
    end else begin
      sa   = isSigned & opA[W-1];
      sb   = isSigned & opB[W-1];
      magA = sa ? -opA : opA;
      magB = sb ? -opB : opB;
      hiInit = extEff ? magA : '0;
      loInit = extEff ? '0 : magA;
    end
  end

  // one iteration
  logic [W:0]   trial;
  logic         qBit;
  logic [W-1:0] remNext;
  always_comb begin
    if (strobe.first) begin
      trial = {1'b0, remReg};
    end else begin
      trial = {remReg, lowReg[W-1]};
    end
    qBit    = trial >= {1'b0, divReg};
    remNext = qBit ? (trial[W-1:0] - divReg) : trial[W-1:0];
  end

  // output stage
  logic [W:0]   limit;
  logic         qFits, failNow, ltB, eqB;
  logic [W-1:0] qVal, rVal, resNow;
  logic [31:0]  condNow;
  always_comb begin
    limit = w32R ? LIM_HALF : LIM_FULL;
    if (sgnR) qFits = negQ ? (qReg <= limit) : (qReg < limit);
    else      qFits = w32R ? ((qReg >> H) == '0) : !qReg[W];
    qVal = negQ ? -qReg[W-1:0] : qReg[W-1:0];
    rVal = negR ? -remReg : remReg;
    if (modR) begin
      if (!w32R)     resNow = rVal;
      else if (sgnR) resNow = {{H{rVal[H-1]}}, rVal[H-1:0]};
      else           resNow = {{H{1'b0}}, rVal[H-1:0]};
    end else begin
      resNow = w32R ? {{H{1'b0}}, qVal[H-1:0]} : qVal;
    end
    failNow = qReg[W] | (~modR & ~qFits);
    ltB = resNow[W-1];
    eqB = (resNow == '0);
    condNow = recR ? {ltB, ~ltB & ~eqB, eqB, soR, 28'd0} : 32'd0;
    if (failNow) begin
      resNow  = '0;
      condNow = FAIL_COND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0; divReg <= '0; lowReg <= '0; qReg <= '0;
      sgnR <= 1'b0; w32R <= 1'b0; modR <= 1'b0; recR <= 1'b0;
      soR <= 1'b0; negQ <= 1'b0; negR <= 1'b0;
      doneOut <= 1'b0; resultOut <= '0; condOut <= '0;
    end else begin
      doneOut <= strobe.finish;
      if (strobe.load) begin
        remReg <= hiInit;
        lowReg <= loInit;
        divReg <= magB;
        qReg   <= '0;
        sgnR <= isSigned; w32R <= is32; modR <= isModulo;
        recR <= recordIn; soR <= sumOvIn;
        negQ <= sa ^ sb;
        negR <= sa;
      end
      if (strobe.step) begin
        remReg <= remNext;
        qReg   <= {qReg[W-1:0], qBit};
        if (!strobe.first) lowReg <= lowReg << 1;
      end
      if (strobe.finish) begin
        resultOut <= resNow;
        condOut   <= condNow;
      end
    end
  end

  // R7
  zero_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && divReg == '0) |=> (resultOut == '0 && condOut == FAIL_COND));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && w32R && !modR) |-> (resultOut[W-1:H] == '0));

  // R10
  no_record_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !recR && resultOut != '0) |-> (condOut == 32'd0));

  // R9
  fail_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && condOut[29] && !recR) |-> (resultOut == '0 && condOut == FAIL_COND));
endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int W = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          isSigned,
  input  logic          is32,
  input  logic          isModulo,
  input  logic          isExtended,
  input  logic          recordIn,
  input  logic          sumOvIn,
  output logic          doneOut,
  output logic [W-1:0]  resultOut,
  output logic [31:0]   condOut
);
  divStrobeT strobe;

  divCtrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .strobe(strobe)
  );

  divDatapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .isSigned(isSigned), .is32(is32),
    .isModulo(isModulo), .isExtended(isExtended),
    .recordIn(recordIn), .sumOvIn(sumOvIn),
    .doneOut(doneOut), .resultOut(resultOut), .condOut(condOut)
  );

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: tb/seqDivider_bench.sv
module seqDivider_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic isSigned = 0, is32 = 0, isModulo = 0, isExtended = 0, recordIn = 0, sumOvIn = 0;
  logic doneOut;
  logic [63:0] resultOut;
  logic [31:0] condOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [63:0] gotRes;
  logic [31:0] gotCond;
  int gotLat;

  always #5 clk = ~clk;

  seqDivider u_seqDivider (
    .clk(clk), .rstN(rstN), .startIn(startIn), .opA(opA), .opB(opB),
    .isSigned(isSigned), .is32(is32), .isModulo(isModulo), .isExtended(isExtended),
    .recordIn(recordIn), .sumOvIn(sumOvIn),
    .doneOut(doneOut), .resultOut(resultOut), .condOut(condOut)
  );

  function automatic logic [95:0] model(input logic [63:0] a, input logic [63:0] b,
      input bit sg, input bit w32, input bit md, input bit ex, input bit rec, input bit so);
    logic [127:0] dd, bb, qq, rr, lim;
    logic [63:0] ma, mb, res, v;
    logic [31:0] cnd;
    bit sa, sb, ok, ee;
    ee = ex & !md;
    if (w32) begin
      sa = sg & a[31]; sb = sg & b[31];
      ma = {32'd0, sa ? -a[31:0] : a[31:0]};
      mb = {32'd0, sb ? -b[31:0] : b[31:0]};
      dd = ee ? ({64'd0, ma} << 32) : {64'd0, ma};
    end else begin
      sa = sg & a[63]; sb = sg & b[63];
      ma = sa ? -a : a;
      mb = sb ? -b : b;
      dd = ee ? {ma, 64'd0} : {64'd0, ma};
    end
    bb = {64'd0, mb};
    ok = (bb != 0);
    res = '0;
    if (ok) begin
      qq = dd / bb; rr = dd % bb;
      if (md) begin
        v = sa ? -rr[63:0] : rr[63:0];
        if (!w32) res = v;
        else if (sg) res = {{32{v[31]}}, v[31:0]};
        else res = {32'd0, v[31:0]};
      end else begin
        if (sg) begin
          lim = w32 ? (128'd1 << 31) : (128'd1 << 63);
          ok = (sa ^ sb) ? (qq <= lim) : (qq < lim);
        end else begin
          ok = w32 ? (qq < (128'd1 << 32)) : (qq < (128'd1 << 64));
        end
        v = (sa ^ sb) ? -qq[63:0] : qq[63:0];
        res = w32 ? {32'd0, v[31:0]} : v;
      end
    end
    if (!ok) return {64'd0, 32'h2000_0000};
    cnd = rec ? {res[63], !res[63] && res != 0, res == 0, so, 28'd0} : 32'd0;
    return {res, cnd};
  endfunction

  task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got res=%h cond=%h expected res=%h cond=%h",
               tag, got[95:32], got[31:0], exp[95:32], exp[31:0]);
    end
  endtask

  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input bit sg, input bit w32,
      input bit md, input bit ex, input bit rec, input bit so);
    @(negedge clk);
    opA = a; opB = b; isSigned = sg; is32 = w32; isModulo = md;
    isExtended = ex; recordIn = rec; sumOvIn = so; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    gotLat = 0;
    for (int i = 0; i < 200; i++) begin
      if (doneOut) break;
      @(posedge clk);
      gotLat++;
      @(negedge clk);
    end
    gotRes = resultOut; gotCond = condOut;
  endtask

  task automatic doOp(input string tag, input logic [63:0] a, input logic [63:0] b,
      input bit sg, input bit w32, input bit md, input bit ex, input bit rec, input bit so);
    runOp(a, b, sg, w32, md, ex, rec, so);
    check(tag, {gotRes, gotCond}, model(a, b, sg, w32, md, ex, rec, so));
  endtask

  function automatic string pickTag(input logic [63:0] b, input bit sg, input bit w32,
      input bit md, input bit ex);
    if ((w32 ? b[31:0] == 0 : b == 0)) return "R7";
    if (md && ex) return "R11";
    if (ex) return "R8";
    if (md && sg) return "R6";
    if (sg) return "R5";
    return "R4";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    bit [5:0] md4;
    void'($urandom(42));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {resultOut, condOut, 31'd0, doneOut}, 96'd0);
    rstN = 1'b1;

    // R2 latency and single-cycle done
    runOp(64'd100, 64'd7, 0, 0, 0, 0, 1, 0);
    checks++;
    if (gotLat != 66) begin
      failures++;
      $display("FAIL R2: got latency=%0d expected 66", gotLat);
    end
    @(negedge clk);
    checks++;
    if (doneOut !== 1'b0) begin
      failures++;
      $display("FAIL R2: got done=%b expected 0", doneOut);
    end

    doOp("R4", 64'd100, 64'd7, 0, 0, 0, 0, 1, 0);
    doOp("R4", 64'd100, 64'd7, 0, 0, 1, 0, 0, 0);
    doOp("R4", 64'hDEAD_BEEF_0000_0064, 64'hFFFF_FFFF_0000_0007, 0, 1, 0, 0, 1, 0);
    doOp("R5", -64'sd7, 64'd2, 1, 0, 0, 0, 1, 0);
    doOp("R5", 64'h0000_0000_FFFF_FFF9, 64'd2, 1, 1, 0, 0, 1, 0);
    doOp("R6", 64'h0000_0000_FFFF_FFF9, 64'd2, 1, 1, 1, 0, 1, 0);
    doOp("R6", -64'sd7, 64'd2, 1, 0, 1, 0, 1, 1);
    doOp("R7", 64'd55, 64'd0, 0, 0, 0, 0, 0, 0);
    doOp("R7", 64'd55, 64'hFFFF_FFFF_0000_0000, 1, 1, 0, 0, 1, 0);
    doOp("R9", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 1, 0);
    doOp("R9", 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, 1, 0, 0, 1, 0);
    doOp("R9", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, 1, 0);
    doOp("R8", 64'd1, 64'd3, 0, 0, 0, 1, 1, 0);
    doOp("R8", 64'd5, 64'd5, 0, 0, 0, 1, 1, 0);
    doOp("R8", -64'sd5, 64'd4, 1, 0, 0, 1, 1, 0);
    doOp("R8", 64'd1, 64'd2, 0, 1, 0, 1, 1, 0);
    doOp("R11", 64'd17, 64'd5, 0, 0, 1, 1, 1, 0);
    doOp("R11", 64'd17, 64'd0, 0, 0, 1, 1, 1, 0);
    doOp("R10", 64'd0, 64'd9, 0, 0, 0, 0, 1, 1);
    doOp("R10", 64'd90, 64'd9, 0, 0, 0, 0, 0, 1);

    // R3 second start while busy is ignored
    @(negedge clk);
    opA = 64'd1000; opB = 64'd10; isSigned = 0; is32 = 0; isModulo = 0;
    isExtended = 0; recordIn = 1; sumOvIn = 0; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (10) @(negedge clk);
    opA = 64'd77; opB = 64'd3; isModulo = 1; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int i = 0; i < 200 && !doneOut; i++) @(negedge clk);
    check("R3", {resultOut, condOut}, model(64'd1000, 64'd10, 0, 0, 0, 0, 1, 0));
    repeat (3) @(negedge clk);
    checks++;
    if (doneOut !== 1'b0) begin
      failures++;
      $display("FAIL R3: got done=%b expected 0", doneOut);
    end

    for (int n = 0; n < 250; n++) begin
      md4 = 6'($urandom);
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 3) == 0) rb = rb >> ($urandom % 64);
      if (($urandom % 16) == 0) rb = '0;
      if (md4[3] && ($urandom % 2) == 0) ra = ra >> ($urandom % 64);
      doOp(pickTag(rb, md4[0], md4[1], md4[2], md4[3]), ra, rb,
           md4[0], md4[1], md4[2], md4[3], md4[4], md4[5]);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule